// File: doc/BRIEF.md
# Flash Command Sequencer

This block is the command front end of a byte-wide NOR-style flash. It has a 1 MiB array split into 16 blocks of 64 KiB. Each block has its own lock bit, and one master lock bit governs every change to those block locks. The host writes commands as bus write cycles on a valid/ready command channel. Most operations take two cycles: a setup code, then a confirm code or the data. The block decodes these cycles and routes host reads to one of three sources: the array, an 8-bit status register, or identifier codes.

Erase, byte write and lock-bit operations run through a write state machine. Each operation stays busy for a number of clock cycles fixed by a parameter. When it finishes, the block fires a one-cycle strobe on the array port, carrying the latched address and data. Erase and byte write can each be paused and later resumed.

A low level on the power-down input aborts all activity. The high-voltage override level on that pin is modelled as a separate digital input. A low programming supply is reported through another input.

Command channel: a write cycle is accepted on any clock edge where `cmd_valid` and `cmd_ready` are both high. `cmd_ready` is low only while `pwd_n` is low. Back-pressure never stalls a command because of an operation in progress. Commands that do not apply in the current state are accepted and then dropped.

Top module: `flash_cmd_seq`

## Requirements
- R1: After reset, `ry_by` and `cmd_ready` are high and reads return array data. The status register reads 80h, and all lock bits read 0.
- R2: Command FFh selects array read, 70h selects status read and 90h selects identifier read. The selected mode holds until another command is written.
- R3: In identifier mode, reads at block 0 return a fixed code at each offset: offset 0 gives `MFR_ID`, offset 1 gives `DEV_ID` and offset 3 gives the master lock in bit 0. Offset 2 of any block gives that block's lock in bit 0. Every other address reads 0.
- R4: 60h followed by 01h sets the lock of the block addressed in the second cycle. 60h followed by F1h sets the master lock. Each stays busy for `LOCK_CYC` cycles.
- R5: Erase or byte write aimed at a locked block is refused. It raises no busy, fires no strobe, and sets status bit 1 plus bit 5 (erase) or bit 4 (write).
- R6: 40h or 10h, followed by data, stays busy for `PROG_CYC` cycles and then fires one `arr_prog` strobe with the second-cycle address and data. 20h followed by D0h stays busy for `ERASE_CYC` cycles and then fires one `arr_erase` strobe. The strobe occurs in the last busy cycle.
- R7: If the second cycle of an erase or lock sequence carries an unexpected code, the sequence is refused and status bits 5 and 4 are set. Error bits stay set across other commands until 50h clears them. Any setup or confirm command switches reads to status.
- R8: B0h during an erase or byte write suspends it. `ry_by` goes high, status bit 6 is set (erase) or bit 2 (write), and the remaining busy time is frozen. D0h resumes the operation, so the total busy time equals the operation's full length.
- R9: While the master lock is set and `hv_ovr` is low, set-block-lock and clear-locks are refused. A refused set-block-lock sets status bits 1 and 4. A refused clear-locks sets status bits 1 and 5. The master lock, once set, stays set.
- R10: 60h followed by D0h clears all block locks together after `ERASE_CYC` busy cycles.
- R11: When `vpp_low` is high at the second cycle, the operation is refused and status bit 3 is set together with bit 5 or bit 4.
- R12: `pwd_n` low aborts the active operation without a strobe. While it is low, `cmd_ready` is low and `ry_by` is high. It also returns reads to array mode and clears the error bits. Lock bits are kept.
- R13: Status layout: bit 7 = ready, bit 6 = erase suspended, bit 5 = erase/clear failure, bit 4 = write/lock-set failure, bit 3 = low supply, bit 2 = write suspended, bit 1 = protection, bit 0 = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pwd_n | input | 1 | Power-down, active low (abort) |
| hv_ovr | input | 1 | High-voltage override on the power-down pin |
| vpp_low | input | 1 | Programming supply below its threshold |
| cmd_valid | input | 1 | Host write cycle present |
| cmd_ready | output | 1 | Write cycle can be accepted |
| cmd_addr | input | ADDR_W | Write cycle address |
| cmd_data | input | 8 | Write cycle data or command code |
| rd_addr | input | ADDR_W | Host read address |
| rd_data | output | 8 | Host read data (combinational) |
| ry_by | output | 1 | High when ready or suspended |
| arr_rdata | input | 8 | Array byte at `rd_addr` from the external array |
| arr_prog | output | 1 | One-cycle byte program strobe |
| arr_erase | output | 1 | One-cycle block erase strobe |
| arr_addr | output | ADDR_W | Target address of the strobe |
| arr_wdata | output | 8 | Data byte of the program strobe |

## Verification
The assertions check four things on every cycle:
- an array strobe appears only inside a busy window, and never two strobes at once;
- power-down forces the command channel closed and `ry_by` high;
- block locks change only at the end of a busy operation;
- the master lock never falls back.

Only the bench scenarios can show the following:
- the exact busy lengths, including how a suspended operation's time is split around the pause;
- the status codes produced by each refusal;
- the identifier map;
- that a refused or aborted operation never reaches the array.

// File: rtl/fcs_pkg.sv
package fcs_pkg;
  typedef enum logic [1:0] {RM_ARRAY, RM_STATUS, RM_IDENT} rmode_t;
  typedef enum logic [1:0] {ST_IDLE, ST_SETUP, ST_BUSY, ST_SUSP} st_t;
  typedef enum logic [1:0] {PS_ERASE, PS_PROG, PS_LOCK} pend_t;
  typedef enum logic [2:0] {OP_ERASE, OP_PROG, OP_SETLK, OP_SETML, OP_CLRLK} op_t;

  localparam logic [7:0] C_RDARR = 8'hFF;
  localparam logic [7:0] C_RDSR  = 8'h70;
  localparam logic [7:0] C_CLRSR = 8'h50;
  localparam logic [7:0] C_RDID  = 8'h90;
  localparam logic [7:0] C_ERASE = 8'h20;
  localparam logic [7:0] C_PROG  = 8'h40;
  localparam logic [7:0] C_PROG2 = 8'h10;
  localparam logic [7:0] C_LOCK  = 8'h60;
  localparam logic [7:0] C_CONF  = 8'hD0;
  localparam logic [7:0] C_SUSP  = 8'hB0;
  localparam logic [7:0] C_SETLK = 8'h01;
  localparam logic [7:0] C_SETML = 8'hF1;
endpackage

// File: rtl/fcs_timer.sv
module fcs_timer #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  input  logic             run,
  output logic             done
);
  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                 cnt <= '0;
    else if (clr)               cnt <= '0;
    else if (load)              cnt <= load_val;
    else if (run && cnt != '0)  cnt <= cnt - CNT_W'(1);
  end

  // finishes in the cycle where the last unit of busy time is spent
  assign done = run && (cnt == CNT_W'(1));
endmodule

// File: rtl/fcs_lockbits.sv
module fcs_lockbits #(
  parameter int BLK_N = 16,
  localparam int BLK_W = $clog2(BLK_N)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             set_blk,
  input  logic [BLK_W-1:0] blk_idx,
  input  logic             set_master,
  input  logic             clr_blk,
  output logic [BLK_N-1:0] blk_lock,
  output logic             master
);
  for (genvar g = 0; g < BLK_N; g++) begin : g_lk
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                                    blk_lock[g] <= 1'b0;
      else if (clr_blk)                              blk_lock[g] <= 1'b0;
      else if (set_blk && blk_idx == BLK_W'(g))      blk_lock[g] <= 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          master <= 1'b0;
    else if (set_master) master <= 1'b1;
  end
endmodule

// File: rtl/fcs_readmux.sv
module fcs_readmux
  import fcs_pkg::*;
#(
  parameter int ADDR_W = 20,
  parameter int BLK_N  = 16,
  parameter logic [7:0] MFR_ID = 8'hB3,
  parameter logic [7:0] DEV_ID = 8'h4E,
  localparam int BLK_W = $clog2(BLK_N),
  localparam int OFS_W = ADDR_W - BLK_W
) (
  input  rmode_t            rmode,
  input  logic [7:0]        status,
  input  logic [7:0]        arr_rdata,
  input  logic [ADDR_W-1:0] rd_addr,
  input  logic [BLK_N-1:0]  blk_lock,
  input  logic              master,
  output logic [7:0]        rd_data
);
  logic [OFS_W-1:0] ofs;
  logic [BLK_W-1:0] blk;
  logic [7:0]       id_byte;

  assign ofs = rd_addr[OFS_W-1:0];
  assign blk = rd_addr[ADDR_W-1 -: BLK_W];

  always_comb begin
    id_byte = 8'h00;
    if (ofs == OFS_W'(2))                          id_byte = {7'b0, blk_lock[blk]};
    else if (blk == '0 && ofs == OFS_W'(0))        id_byte = MFR_ID;
    else if (blk == '0 && ofs == OFS_W'(1))        id_byte = DEV_ID;
    else if (blk == '0 && ofs == OFS_W'(3))        id_byte = {7'b0, master};
  end

  always_comb begin
    case (rmode)
      RM_STATUS: rd_data = status;
      RM_IDENT:  rd_data = id_byte;
      default:   rd_data = arr_rdata;
    endcase
  end
endmodule

// File: rtl/flash_cmd_seq.sv
module flash_cmd_seq
  import fcs_pkg::*;
#(
  parameter int ADDR_W    = 20,
  parameter int BLK_N     = 16,
  parameter int ERASE_CYC = 64,
  parameter int PROG_CYC  = 16,
  parameter int LOCK_CYC  = 32,
  parameter logic [7:0] MFR_ID = 8'hB3,
  parameter logic [7:0] DEV_ID = 8'h4E
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              pwd_n,
  input  logic              hv_ovr,
  input  logic              vpp_low,
  input  logic              cmd_valid,
  output logic              cmd_ready,
  input  logic [ADDR_W-1:0] cmd_addr,
  input  logic [7:0]        cmd_data,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [7:0]        rd_data,
  output logic              ry_by,
  input  logic [7:0]        arr_rdata,
  output logic              arr_prog,
  output logic              arr_erase,
  output logic [ADDR_W-1:0] arr_addr,
  output logic [7:0]        arr_wdata
);
  localparam int BLK_W = $clog2(BLK_N);
  localparam int MAXC  = (ERASE_CYC > PROG_CYC) ?
                         ((ERASE_CYC > LOCK_CYC) ? ERASE_CYC : LOCK_CYC) :
                         ((PROG_CYC > LOCK_CYC) ? PROG_CYC : LOCK_CYC);
  localparam int CNT_W = $clog2(MAXC + 1);

  st_t               st;
  pend_t             pend;
  op_t               op, nxt_op;
  rmode_t            rmode;
  logic [ADDR_W-1:0] op_addr;
  logic [7:0]        op_data;
  logic              e_es, e_ws, e_vp, e_pr;
  logic              cmd_fire, seq_err, prot, go, erase_cls, tmr_done;
  logic [CNT_W-1:0]  load_val;
  logic [BLK_W-1:0]  cmd_blk;
  logic [BLK_N-1:0]  blk_lock;
  logic              master_lk;
  logic [7:0]        status;

  assign cmd_ready = pwd_n;
  assign cmd_fire  = cmd_valid && cmd_ready;
  assign cmd_blk   = cmd_addr[ADDR_W-1 -: BLK_W];

  // second-cycle decode and admission checks
  always_comb begin
    nxt_op  = OP_ERASE;
    seq_err = 1'b0;
    case (pend)
      PS_ERASE: seq_err = (cmd_data != C_CONF);
      PS_PROG:  nxt_op  = OP_PROG;
      PS_LOCK: begin
        if (cmd_data == C_SETLK)      nxt_op = OP_SETLK;
        else if (cmd_data == C_SETML) nxt_op = OP_SETML;
        else if (cmd_data == C_CONF)  nxt_op = OP_CLRLK;
        else                          seq_err = 1'b1;
      end
      default:  seq_err = 1'b1;
    endcase
    erase_cls = (nxt_op == OP_ERASE) || (nxt_op == OP_CLRLK);
    prot = (((nxt_op == OP_ERASE) || (nxt_op == OP_PROG)) && blk_lock[cmd_blk]) ||
           (((nxt_op == OP_SETLK) || (nxt_op == OP_CLRLK)) && master_lk && !hv_ovr);
    go = cmd_fire && (st == ST_SETUP) && !seq_err && !vpp_low && !prot;
    case (nxt_op)
      OP_PROG:             load_val = CNT_W'(PROG_CYC);
      OP_SETLK, OP_SETML:  load_val = CNT_W'(LOCK_CYC);
      default:             load_val = CNT_W'(ERASE_CYC);
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= ST_IDLE; pend <= PS_ERASE; op <= OP_ERASE; rmode <= RM_ARRAY;
      op_addr <= '0; op_data <= '0;
      e_es <= 1'b0; e_ws <= 1'b0; e_vp <= 1'b0; e_pr <= 1'b0;
    end else if (!pwd_n) begin
      st <= ST_IDLE; rmode <= RM_ARRAY;
      e_es <= 1'b0; e_ws <= 1'b0; e_vp <= 1'b0; e_pr <= 1'b0;
    end else begin
      case (st)
        ST_IDLE: if (cmd_fire) begin
          case (cmd_data)
            C_RDARR: rmode <= RM_ARRAY;
            C_RDSR:  rmode <= RM_STATUS;
            C_RDID:  rmode <= RM_IDENT;
            C_CLRSR: begin e_es <= 1'b0; e_ws <= 1'b0; e_vp <= 1'b0; e_pr <= 1'b0; end
            C_ERASE:        begin st <= ST_SETUP; pend <= PS_ERASE; rmode <= RM_STATUS; end
            C_PROG, C_PROG2: begin st <= ST_SETUP; pend <= PS_PROG;  rmode <= RM_STATUS; end
            C_LOCK:         begin st <= ST_SETUP; pend <= PS_LOCK;  rmode <= RM_STATUS; end
            default: ;
          endcase
        end
        ST_SETUP: if (cmd_fire) begin
          rmode   <= RM_STATUS;
          op      <= nxt_op;
          op_addr <= cmd_addr;
          op_data <= cmd_data;
          st      <= go ? ST_BUSY : ST_IDLE;
          if (seq_err) begin
            e_es <= 1'b1; e_ws <= 1'b1;
          end else if (vpp_low || prot) begin
            if (vpp_low) e_vp <= 1'b1;
            if (prot)    e_pr <= 1'b1;
            if (erase_cls) e_es <= 1'b1;
            else           e_ws <= 1'b1;
          end
        end
        ST_BUSY: begin
          if (tmr_done) st <= ST_IDLE;
          else if (cmd_fire && cmd_data == C_SUSP &&
                   (op == OP_ERASE || op == OP_PROG)) st <= ST_SUSP;
        end
        ST_SUSP: if (cmd_fire) begin
          case (cmd_data)
            C_RDARR: rmode <= RM_ARRAY;
            C_RDSR:  rmode <= RM_STATUS;
            C_RDID:  rmode <= RM_IDENT;
            C_CLRSR: begin e_es <= 1'b0; e_ws <= 1'b0; e_vp <= 1'b0; e_pr <= 1'b0; end
            C_CONF:  begin st <= ST_BUSY; rmode <= RM_STATUS; end
            default: ;
          endcase
        end
        default: st <= ST_IDLE;
      endcase
    end
  end

  fcs_timer #(.CNT_W(CNT_W)) u_tmr (
    .clk(clk), .rst_n(rst_n), .clr(!pwd_n), .load(go), .load_val(load_val),
    .run(st == ST_BUSY), .done(tmr_done)
  );

  fcs_lockbits #(.BLK_N(BLK_N)) u_lk (
    .clk(clk), .rst_n(rst_n),
    .set_blk(tmr_done && op == OP_SETLK),
    .blk_idx(op_addr[ADDR_W-1 -: BLK_W]),
    .set_master(tmr_done && op == OP_SETML),
    .clr_blk(tmr_done && op == OP_CLRLK),
    .blk_lock(blk_lock), .master(master_lk)
  );

  assign status = {st != ST_BUSY, st == ST_SUSP && op == OP_ERASE, e_es, e_ws,
                   e_vp, st == ST_SUSP && op == OP_PROG, e_pr, 1'b0};

  fcs_readmux #(.ADDR_W(ADDR_W), .BLK_N(BLK_N), .MFR_ID(MFR_ID), .DEV_ID(DEV_ID)) u_rd (
    .rmode(rmode), .status(status), .arr_rdata(arr_rdata), .rd_addr(rd_addr),
    .blk_lock(blk_lock), .master(master_lk), .rd_data(rd_data)
  );

  assign ry_by     = (st != ST_BUSY);
  assign arr_prog  = tmr_done && op == OP_PROG;
  assign arr_erase = tmr_done && op == OP_ERASE;
  assign arr_addr  = op_addr;
  assign arr_wdata = op_data;
endmodule

// File: rtl/fcs_chk.sv
module fcs_chk #(
  parameter int BLK_N = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             pwd_n,
  input logic             cmd_ready,
  input logic             ry_by,
  input logic             arr_prog,
  input logic             arr_erase,
  input logic [BLK_N-1:0] blk_lock,
  input logic             master
);
  a_r6_strobe_in_busy: assert property (@(posedge clk) disable iff (!rst_n)
    (arr_prog || arr_erase) |-> !ry_by);
  a_r6_single_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({arr_prog, arr_erase}));
  a_r12_pwd_ready: assert property (@(posedge clk) disable iff (!rst_n)
    !pwd_n |=> ry_by);
  a_r12_pwd_closed: assert property (@(posedge clk) disable iff (!rst_n)
    !pwd_n |-> !cmd_ready);
  a_r10_lock_change_busy: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(blk_lock) |-> $past(!ry_by));
  a_r9_master_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    $past(master) |-> master);
endmodule

bind flash_cmd_seq fcs_chk #(.BLK_N(BLK_N)) u_chk (
  .clk(clk), .rst_n(rst_n), .pwd_n(pwd_n), .cmd_ready(cmd_ready), .ry_by(ry_by),
  .arr_prog(arr_prog), .arr_erase(arr_erase), .blk_lock(blk_lock), .master(master_lk)
);

// File: tb/tb_flash_cmd_seq.sv
`timescale 1ns/1ps
module tb_flash_cmd_seq;
  localparam int EC = 8, PC = 4, LC = 3;
  logic clk = 0, rst_n = 0, pwd_n = 1, hv_ovr = 0, vpp_low = 0, cmd_valid = 0;
  logic [19:0] cmd_addr = '0, rd_addr = '0;
  logic [7:0]  cmd_data = '0;
  logic cmd_ready, ry_by, arr_prog, arr_erase;
  logic [7:0] rd_data, arr_wdata, arr_rdata;
  logic [19:0] arr_addr;
  int nvec = 0, nfail = 0, n_prog = 0, n_erase = 0, n;
  logic [19:0] cap_pa, cap_ea;
  logic [7:0]  cap_pd;
  bit finished = 0;

  always #4 clk = ~clk;
  assign arr_rdata = rd_addr[7:0] ^ 8'h5A;

  flash_cmd_seq #(.ERASE_CYC(EC), .PROG_CYC(PC), .LOCK_CYC(LC),
                  .MFR_ID(8'hB3), .DEV_ID(8'h4E)) dut (
    .clk(clk), .rst_n(rst_n), .pwd_n(pwd_n), .hv_ovr(hv_ovr), .vpp_low(vpp_low),
    .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_addr(cmd_addr), .cmd_data(cmd_data),
    .rd_addr(rd_addr), .rd_data(rd_data), .ry_by(ry_by), .arr_rdata(arr_rdata),
    .arr_prog(arr_prog), .arr_erase(arr_erase), .arr_addr(arr_addr), .arr_wdata(arr_wdata));

  always @(posedge clk) begin
    if (arr_prog)  begin n_prog++;  cap_pa = arr_addr; cap_pd = arr_wdata; end
    if (arr_erase) begin n_erase++; cap_ea = arr_addr; end
  end

  // {valid, cmd, cmd addr, read addr, expected byte, requirement}
  localparam logic [60:0] VEC [13] = '{
    {1'b1, 8'hFF, 20'h0,     20'h00012, 8'h48, 4'd2},  // R2 array read
    {1'b0, 8'h00, 20'h0,     20'h00034, 8'h6E, 4'd2},  // R2 mode holds
    {1'b1, 8'h90, 20'h0,     20'h00000, 8'hB3, 4'd3},  // R3 maker code
    {1'b0, 8'h00, 20'h0,     20'h00001, 8'h4E, 4'd3},  // R3 device code
    {1'b0, 8'h00, 20'h0,     20'h10002, 8'h00, 4'd3},  // R3 block lock
    {1'b0, 8'h00, 20'h0,     20'h00003, 8'h00, 4'd3},  // R3 master lock
    {1'b0, 8'h00, 20'h0,     20'h00004, 8'h00, 4'd3},  // R3 other offset
    {1'b1, 8'h70, 20'h0,     20'h00000, 8'h80, 4'd13}, // R13 idle status
    {1'b1, 8'h20, 20'h0,     20'h00000, 8'h80, 4'd7},  // R7 setup -> status
    {1'b1, 8'h55, 20'h10000, 20'h00000, 8'hB0, 4'd7},  // R7 bad confirm
    {1'b1, 8'h70, 20'h0,     20'h00000, 8'hB0, 4'd7},  // R7 sticky
    {1'b1, 8'h50, 20'h0,     20'h00000, 8'h80, 4'd7},  // R7 cleared
    {1'b1, 8'hFF, 20'h0,     20'h000A5, 8'hFF, 4'd2}   // R2 back to array
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    nvec++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic send(input logic [7:0] d, input logic [19:0] a);
    cmd_valid = 1; cmd_data = d; cmd_addr = a;
    @(posedge clk); @(negedge clk);
    cmd_valid = 0;
  endtask

  task automatic rdchk(input string req, input logic [19:0] a, input logic [7:0] exp);
    rd_addr = a; #1;
    chk(req, rd_data, exp);
  endtask

  task automatic busy_len(output int cnt);
    cnt = 0;
    while (!ry_by && cnt < 1000) begin @(negedge clk); cnt++; end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    chk("R1 ry_by", ry_by, 1);
    chk("R1 cmd_ready", cmd_ready, 1);
    rdchk("R1 array mode", 20'h00012, 8'h48);

    for (int i = 0; i < 13; i++) begin
      if (VEC[i][60]) send(VEC[i][59:52], VEC[i][51:32]);
      rd_addr = VEC[i][31:12]; #1;
      chk($sformatf("R%0d vec%0d", VEC[i][3:0], i), rd_data, VEC[i][11:4]);
    end

    // R4 set block 2 lock
    send(8'h60, 20'h20000); send(8'h01, 20'h20000);
    busy_len(n); chk("R4 lock busy", n, LC);
    send(8'h90, 0);
    rdchk("R4 block2 locked", 20'h20002, 8'h01);
    rdchk("R4 block3 open", 20'h30002, 8'h00);

    // R5 locked block refusals
    send(8'h20, 0); send(8'hD0, 20'h20000);
    chk("R5 no busy", ry_by, 1);
    rdchk("R5 erase status", 0, 8'hA2);
    send(8'h50, 0);
    send(8'h40, 0); send(8'h77, 20'h20010);
    rdchk("R5 write status", 0, 8'h92);
    chk("R5 no strobes", n_prog + n_erase, 0);
    send(8'h50, 0);

    // R6 byte write
    send(8'h40, 0); send(8'h3C, 20'h00100);
    busy_len(n); chk("R6 prog busy", n, PC);
    chk("R6 one prog strobe", n_prog, 1);
    chk("R6 prog addr", cap_pa, 20'h00100);
    chk("R6 prog data", cap_pd, 8'h3C);
    rdchk("R6 status", 0, 8'h80);

    // R8 erase suspend/resume
    send(8'h20, 0); send(8'hD0, 20'h05555);
    send(8'hB0, 0);
    rdchk("R8 erase suspended", 0, 8'hC0);
    chk("R8 ry_by high", ry_by, 1);
    send(8'hFF, 0);
    rdchk("R8 array during suspend", 20'h00777, 8'h2D);
    repeat (5) @(negedge clk);
    chk("R8 frozen", n_erase, 0);
    send(8'hD0, 0);
    busy_len(n); chk("R8 remaining erase", n, EC - 1);
    chk("R6 erase strobe", n_erase, 1);
    chk("R6 erase addr", cap_ea, 20'h05555);
    rdchk("R8 done status", 0, 8'h80);

    // R8 byte write suspend
    send(8'h10, 0); send(8'hAA, 20'h10010);
    send(8'hB0, 0);
    rdchk("R8 write suspended", 0, 8'h84);
    send(8'hD0, 0);
    busy_len(n); chk("R8 remaining write", n, PC - 1);
    chk("R8 write strobe", n_prog, 2);

    // R9 master lock gating
    send(8'h60, 0); send(8'hF1, 0);
    busy_len(n); chk("R4 master busy", n, LC);
    send(8'h60, 0); send(8'hD0, 0);
    chk("R9 clear refused", ry_by, 1);
    rdchk("R9 clear status", 0, 8'hA2);
    send(8'h50, 0);
    send(8'h60, 0); send(8'h01, 20'h30000);
    rdchk("R9 set refused", 0, 8'h92);
    send(8'h50, 0);
    send(8'h90, 0);
    rdchk("R9 block2 kept", 20'h20002, 8'h01);
    rdchk("R9 block3 not set", 20'h30002, 8'h00);
    rdchk("R3 master bit", 20'h00003, 8'h01);

    // R10 clear all with override
    hv_ovr = 1;
    send(8'h60, 0); send(8'h01, 20'h50000);
    busy_len(n);
    send(8'h60, 0); send(8'hD0, 0);
    busy_len(n); chk("R10 clear busy", n, EC);
    send(8'h90, 0);
    rdchk("R10 block2 cleared", 20'h20002, 8'h00);
    rdchk("R10 block5 cleared", 20'h50002, 8'h00);
    hv_ovr = 0;

    // R11 low supply
    vpp_low = 1;
    send(8'h40, 0); send(8'h11, 20'h00200);
    chk("R11 no busy", ry_by, 1);
    rdchk("R11 status", 0, 8'h98);
    send(8'h50, 0);
    rdchk("R7 clear after vpp", 0, 8'h80);
    vpp_low = 0;

    // R12 power-down abort
    send(8'h20, 0); send(8'hD0, 20'h00000);
    @(negedge clk);
    pwd_n = 0;
    @(negedge clk);
    chk("R12 cmd_ready low", cmd_ready, 0);
    chk("R12 ry_by high", ry_by, 1);
    pwd_n = 1;
    @(negedge clk);
    rdchk("R12 array mode", 20'h00012, 8'h48);
    repeat (EC + 2) @(negedge clk);
    chk("R12 no strobe", n_erase, 1);
    send(8'h70, 0);
    rdchk("R12 status cleared", 0, 8'h80);
    send(8'h90, 0);
    rdchk("R12 master kept", 20'h00003, 8'h01);

    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      nfail++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
      $finish;
    end
  end
endmodule